// File: doc/BRIEF.md
# Linked-List DMA Channel

This block is one DMA channel that copies 32-bit words between a host-side memory port and a local-side memory port. Software programs it through a small register interface. In direct mode the channel runs a single transfer from the address, count and direction held in its own registers. In chained mode it reads a 16-byte descriptor from memory, runs that element, and then follows the next-pointer to the next descriptor. It keeps doing this until it reaches an element marked as the last one.

The low four bits of each descriptor's next-pointer word are per-element flags: list location, last element, interrupt-on-element and direction. A mode bit can make the channel write zero back into the count field of each descriptor once that element has completed. A command/status byte starts, pauses and aborts the channel and clears its interrupt. The same byte reports done, interrupt and busy. The interrupt output follows an internal flag, which is set by element interrupts and, when enabled, by completion of the whole job.

Both memory ports use a simple request/response handshake. A request is accepted when valid and ready are high together. A write needs nothing more. A read returns exactly one response with valid and data in a later cycle.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset, every register reads as zero, `irq` is low, and neither memory port has a request valid.
- R2: Register 5 is the command/status byte. Written bits: bit0 enable, bit1 start, bit2 abort, bit3 clear interrupt. Start acts only when the same write also sets bit0 and the channel is idle. When read: bit0 enable, bit2 abort pending, bit4 done, bit5 interrupt flag, bit6 busy. Starting clears done.
- R3: Direct mode (mode register 0, bit0 = 0) moves ceil(count/4) words. Mode bit4 selects the direction: 0 means read host and write local, 1 means read local and write host.
- R4: Each word moves the host address (register 1) and the local address (register 2) up by 4. The count (register 3) goes down by 4 and stops at 0. The final values can be read back.
- R5: When mode bit1 (local-address hold) is set, the local address stays the same for every word.
- R6: Chained mode (mode bit0 = 1) fetches four words starting at the descriptor address (register 4, with bits 3:0 cleared), in this order: host address, local address, count, next word. Bit0 of register 4 picks the side the fetch reads from (1 host, 0 local).
- R7: In the next word, bit1 marks the last element, bit2 raises the interrupt flag when the element finishes, and bit3 sets the direction to local-to-host. After a non-final element the whole word is loaded into register 4, so its bit0 selects the side of the next fetch.
- R8: When mode bit2 (clear count) is set, the channel writes zero to descriptor offset 8 on the list side after each element.
- R9: Finishing a job sets the interrupt flag only when mode bit3 is set. Writing bit3 of the command byte clears the flag. `irq` follows the flag.
- R10: An element or direct transfer with a count of zero makes no data accesses.
- R11: An abort lets the access in progress complete. The channel then stops, sets done, drops busy and issues no further requests.
- R12: While enable is 0, the channel issues no new request. It resumes when enable is set again.
- R13: Writes to registers 0 to 4 while busy are ignored.
- R14: Only the low 23 bits of a count are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index 0..5 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt output |
| host_req_valid | output | 1 | Host request valid |
| host_req_ready | input | 1 | Host request ready |
| host_req_write | output | 1 | Host request is a write |
| host_req_addr | output | 32 | Host byte address |
| host_req_wdata | output | 32 | Host write data |
| host_rsp_valid | input | 1 | Host read response valid |
| host_rsp_data | input | 32 | Host read response data |
| local_req_valid | output | 1 | Local request valid |
| local_req_ready | input | 1 | Local request ready |
| local_req_write | output | 1 | Local request is a write |
| local_req_addr | output | 32 | Local byte address |
| local_req_wdata | output | 32 | Local write data |
| local_rsp_valid | input | 1 | Local read response valid |
| local_rsp_data | input | 32 | Local read response data |

## Verification
The assertions assume that each memory port returns exactly one read response for each accepted read, that no response arrives unrequested, and that `reg_addr` names one of the six registers whenever `reg_we` is high. The bench memory models keep to these rules. They respond one cycle after acceptance and toggle ready in a fixed pattern, so that requests are sometimes held across stalled cycles. The bench writes registers 0 to 4 while busy only in the case that checks those writes are ignored.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  localparam logic [2:0] REG_MODE  = 3'd0;
  localparam logic [2:0] REG_HOST  = 3'd1;
  localparam logic [2:0] REG_LOCAL = 3'd2;
  localparam logic [2:0] REG_COUNT = 3'd3;
  localparam logic [2:0] REG_DPTR  = 3'd4;
  localparam logic [2:0] REG_CMD   = 3'd5;

  localparam int MODE_W       = 5;
  localparam int MODE_CHAIN   = 0;
  localparam int MODE_HOLD    = 1;
  localparam int MODE_CLRCNT  = 2;
  localparam int MODE_DONEIRQ = 3;
  localparam int MODE_DIR     = 4;

  localparam int CMD_EN     = 0;
  localparam int CMD_START  = 1;
  localparam int CMD_ABORT  = 2;
  localparam int CMD_CLRINT = 3;

  localparam int LNK_SIDE = 0;
  localparam int LNK_END  = 1;
  localparam int LNK_IRQ  = 2;
  localparam int LNK_DIR  = 3;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_FWAIT, S_RD, S_RWAIT, S_WR, S_WB, S_ELEM, S_FIN
  } seq_state_t;

endpackage

// File: rtl/dma_cmd_status.sv
module dma_cmd_status
  import dma_chain_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wbyte,
  input  logic       busy,
  input  logic       finish,
  input  logic       link_irq,
  input  logic       done_irq_en,
  output logic       enable,
  output logic       start,
  output logic       abort_pend,
  output logic       done,
  output logic       int_flag,
  output logic       irq,
  output logic [7:0] status
);

  logic cmd_wr;
  assign cmd_wr = reg_we && (reg_addr == REG_CMD);
  assign start  = cmd_wr && reg_wbyte[CMD_EN] && reg_wbyte[CMD_START] && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable     <= 1'b0;
      abort_pend <= 1'b0;
      done       <= 1'b0;
      int_flag   <= 1'b0;
    end else begin
      if (cmd_wr) enable <= reg_wbyte[CMD_EN];
      if (finish) abort_pend <= 1'b0;
      else if (cmd_wr && reg_wbyte[CMD_ABORT] && busy) abort_pend <= 1'b1;
      if (start) done <= 1'b0;
      else if (finish) done <= 1'b1;
      if (link_irq || (finish && done_irq_en)) int_flag <= 1'b1;
      else if (cmd_wr && reg_wbyte[CMD_CLRINT]) int_flag <= 1'b0;
    end
  end

  assign irq    = int_flag;
  assign status = {1'b0, busy, int_flag, done, 1'b0, abort_pend, 1'b0, enable};

  assert_start_clears_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);
  assert_finish_sets_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (done && !abort_pend));
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !done_irq_en && !link_irq && !int_flag) |=> !int_flag);

endmodule

// File: rtl/dma_port_route.sv
module dma_port_route #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              req_valid,
  input  logic              req_side,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              host_req_valid,
  input  logic              host_req_ready,
  output logic              host_req_write,
  output logic [ADDR_W-1:0] host_req_addr,
  output logic [DATA_W-1:0] host_req_wdata,
  input  logic              host_rsp_valid,
  input  logic [DATA_W-1:0] host_rsp_data,
  output logic              local_req_valid,
  input  logic              local_req_ready,
  output logic              local_req_write,
  output logic [ADDR_W-1:0] local_req_addr,
  output logic [DATA_W-1:0] local_req_wdata,
  input  logic              local_rsp_valid,
  input  logic [DATA_W-1:0] local_rsp_data
);

  assign host_req_valid  = req_valid && req_side;
  assign host_req_write  = req_write;
  assign host_req_addr   = req_addr;
  assign host_req_wdata  = req_wdata;
  assign local_req_valid = req_valid && !req_side;
  assign local_req_write = req_write;
  assign local_req_addr  = req_addr;
  assign local_req_wdata = req_wdata;

  assign req_ready = req_side ? host_req_ready : local_req_ready;
  assign rsp_valid = req_side ? host_rsp_valid : local_rsp_valid;
  assign rsp_data  = req_side ? host_rsp_data  : local_rsp_data;

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              start,
  input  logic              enable,
  input  logic              abort_pend,
  output logic [MODE_W-1:0] mode_q,
  output logic [ADDR_W-1:0] host_q,
  output logic [ADDR_W-1:0] local_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [ADDR_W-1:0] dptr_q,
  output logic              busy,
  output logic              finish,
  output logic              link_irq,
  output logic              req_valid,
  output logic              req_side,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data
);

  localparam int BEAT_BYTES = DATA_W / 8;

  seq_state_t        state_q;
  logic [1:0]        fidx_q;
  logic [DATA_W-1:0] nxt_q;
  logic [DATA_W-1:0] dat_q;
  logic              hold_q;

  function automatic logic [CNT_W-1:0] after_beat(input logic [CNT_W-1:0] c);
    return (c > CNT_W'(BEAT_BYTES)) ? c - CNT_W'(BEAT_BYTES) : '0;
  endfunction

  function automatic logic [ADDR_W-1:0] desc_addr(input logic [ADDR_W-1:0] ptr,
                                                  input logic [1:0] idx);
    return {ptr[ADDR_W-1:4], idx, 2'b00};
  endfunction

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input logic hold);
    return hold ? a : a + ADDR_W'(BEAT_BYTES);
  endfunction

  logic chain, eff_dir, list_side, go, accept;
  logic [CNT_W-1:0] cnt_next;

  assign chain     = mode_q[MODE_CHAIN];
  assign eff_dir   = chain ? nxt_q[LNK_DIR] : mode_q[MODE_DIR];
  assign list_side = dptr_q[LNK_SIDE];
  assign go        = enable && !abort_pend;
  assign accept    = req_valid && req_ready;
  assign cnt_next  = after_beat(cnt_q);
  assign busy      = (state_q != S_IDLE);
  assign finish    = (state_q == S_FIN);
  assign link_irq  = (state_q == S_ELEM) && chain && nxt_q[LNK_IRQ];

  always_comb begin
    req_valid = 1'b0;
    req_side  = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    case (state_q)
      S_FETCH: begin
        req_valid = go || hold_q;
        req_side  = list_side;
        req_addr  = desc_addr(dptr_q, fidx_q);
      end
      S_FWAIT: req_side = list_side;
      S_RD: begin
        req_valid = go || hold_q;
        req_side  = !eff_dir;
        req_addr  = eff_dir ? local_q : host_q;
      end
      S_RWAIT: req_side = !eff_dir;
      S_WR: begin
        req_valid = 1'b1;
        req_side  = eff_dir;
        req_write = 1'b1;
        req_addr  = eff_dir ? host_q : local_q;
        req_wdata = dat_q;
      end
      S_WB: begin
        req_valid = 1'b1;
        req_side  = list_side;
        req_write = 1'b1;
        req_addr  = desc_addr(dptr_q, 2'd2);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      mode_q  <= '0;
      host_q  <= '0;
      local_q <= '0;
      cnt_q   <= '0;
      dptr_q  <= '0;
      nxt_q   <= '0;
      dat_q   <= '0;
      fidx_q  <= '0;
      hold_q  <= 1'b0;
    end else begin
      hold_q <= req_valid && !req_ready;
      case (state_q)
        S_IDLE: begin
          if (reg_we) begin
            case (reg_addr)
              REG_MODE:  mode_q  <= reg_wdata[MODE_W-1:0];
              REG_HOST:  host_q  <= ADDR_W'(reg_wdata);
              REG_LOCAL: local_q <= ADDR_W'(reg_wdata);
              REG_COUNT: cnt_q   <= reg_wdata[CNT_W-1:0];
              REG_DPTR:  dptr_q  <= ADDR_W'(reg_wdata);
              default: ;
            endcase
          end
          if (start) begin
            nxt_q  <= '0;
            fidx_q <= '0;
            if (chain)              state_q <= S_FETCH;
            else if (cnt_q == '0)   state_q <= S_FIN;
            else                    state_q <= S_RD;
          end
        end
        S_FETCH: begin
          if (accept)                      state_q <= S_FWAIT;
          else if (abort_pend && !hold_q)  state_q <= S_FIN;
        end
        S_FWAIT: begin
          if (rsp_valid) begin
            case (fidx_q)
              2'd0: host_q  <= ADDR_W'(rsp_data);
              2'd1: local_q <= ADDR_W'(rsp_data);
              2'd2: cnt_q   <= rsp_data[CNT_W-1:0];
              default: nxt_q <= rsp_data;
            endcase
            if (fidx_q == 2'd3) begin
              if (cnt_q != '0)                state_q <= S_RD;
              else if (mode_q[MODE_CLRCNT])   state_q <= S_WB;
              else                            state_q <= S_ELEM;
            end else begin
              fidx_q  <= fidx_q + 2'd1;
              state_q <= S_FETCH;
            end
          end
        end
        S_RD: begin
          if (accept)                      state_q <= S_RWAIT;
          else if (abort_pend && !hold_q)  state_q <= S_FIN;
        end
        S_RWAIT: begin
          if (rsp_valid) begin
            dat_q   <= rsp_data;
            state_q <= S_WR;
          end
        end
        S_WR: begin
          if (accept) begin
            host_q  <= step_addr(host_q, 1'b0);
            local_q <= step_addr(local_q, mode_q[MODE_HOLD]);
            cnt_q   <= cnt_next;
            if (cnt_next != '0)                     state_q <= S_RD;
            else if (chain && mode_q[MODE_CLRCNT])  state_q <= S_WB;
            else                                    state_q <= S_ELEM;
          end
        end
        S_WB: begin
          if (accept) state_q <= S_ELEM;
        end
        S_ELEM: begin
          if (abort_pend || !chain || nxt_q[LNK_END]) begin
            state_q <= S_FIN;
          end else begin
            dptr_q  <= ADDR_W'(nxt_q);
            fidx_q  <= '0;
            state_q <= S_FETCH;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R12: an offered request is held until taken, even across pause or abort
  assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_write)));
  assert_local_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WR && accept && mode_q[MODE_HOLD]) |=> $stable(local_q));
  assert_count_falls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WR && accept) |=> ((cnt_q < $past(cnt_q)) || (cnt_q == '0)));
  assert_zero_skip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FWAIT && rsp_valid && fidx_q == 2'd3 && cnt_q == '0) |=> (state_q != S_RD));

endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              host_req_valid,
  input  logic              host_req_ready,
  output logic              host_req_write,
  output logic [ADDR_W-1:0] host_req_addr,
  output logic [DATA_W-1:0] host_req_wdata,
  input  logic              host_rsp_valid,
  input  logic [DATA_W-1:0] host_rsp_data,
  output logic              local_req_valid,
  input  logic              local_req_ready,
  output logic              local_req_write,
  output logic [ADDR_W-1:0] local_req_addr,
  output logic [DATA_W-1:0] local_req_wdata,
  input  logic              local_rsp_valid,
  input  logic [DATA_W-1:0] local_rsp_data
);

  logic [MODE_W-1:0] mode_q;
  logic [ADDR_W-1:0] host_q, local_q, dptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy, finish, link_irq;
  logic              enable, start, abort_pend, done, int_flag;
  logic [7:0]        status;
  logic              req_valid, req_side, req_write, req_ready, rsp_valid;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata, rsp_data;

  dma_cmd_status u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wbyte   (reg_wdata[7:0]),
    .busy        (busy),
    .finish      (finish),
    .link_irq    (link_irq),
    .done_irq_en (mode_q[MODE_DONEIRQ]),
    .enable      (enable),
    .start       (start),
    .abort_pend  (abort_pend),
    .done        (done),
    .int_flag    (int_flag),
    .irq         (irq),
    .status      (status)
  );

  dma_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .start      (start),
    .enable     (enable),
    .abort_pend (abort_pend),
    .mode_q     (mode_q),
    .host_q     (host_q),
    .local_q    (local_q),
    .cnt_q      (cnt_q),
    .dptr_q     (dptr_q),
    .busy       (busy),
    .finish     (finish),
    .link_irq   (link_irq),
    .req_valid  (req_valid),
    .req_side   (req_side),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data)
  );

  dma_port_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_route (
    .req_valid       (req_valid),
    .req_side        (req_side),
    .req_write       (req_write),
    .req_addr        (req_addr),
    .req_wdata       (req_wdata),
    .req_ready       (req_ready),
    .rsp_valid       (rsp_valid),
    .rsp_data        (rsp_data),
    .host_req_valid  (host_req_valid),
    .host_req_ready  (host_req_ready),
    .host_req_write  (host_req_write),
    .host_req_addr   (host_req_addr),
    .host_req_wdata  (host_req_wdata),
    .host_rsp_valid  (host_rsp_valid),
    .host_rsp_data   (host_rsp_data),
    .local_req_valid (local_req_valid),
    .local_req_ready (local_req_ready),
    .local_req_write (local_req_write),
    .local_req_addr  (local_req_addr),
    .local_req_wdata (local_req_wdata),
    .local_rsp_valid (local_rsp_valid),
    .local_rsp_data  (local_rsp_data)
  );

  always_comb begin
    case (reg_addr)
      REG_MODE:  reg_rdata = {{(DATA_W-MODE_W){1'b0}}, mode_q};
      REG_HOST:  reg_rdata = DATA_W'(host_q);
      REG_LOCAL: reg_rdata = DATA_W'(local_q);
      REG_COUNT: reg_rdata = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
      REG_DPTR:  reg_rdata = DATA_W'(dptr_q);
      REG_CMD:   reg_rdata = {{(DATA_W-8){1'b0}}, status};
      default:   reg_rdata = '0;
    endcase
  end

  // R1/R11: no traffic on either port unless the sequencer reports busy
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!host_req_valid && !local_req_valid));
  assert_one_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_req_valid && local_req_valid));

endmodule

// File: tb/dma_chain_engine_tb.sv
module dma_chain_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        host_req_valid, host_req_write, local_req_valid, local_req_write;
  logic        host_req_ready = 1'b0, local_req_ready = 1'b0;
  logic [31:0] host_req_addr, host_req_wdata, local_req_addr, local_req_wdata;
  logic        host_rsp_valid = 1'b0, local_rsp_valid = 1'b0;
  logic [31:0] host_rsp_data = '0, local_rsp_data = '0;

  logic [31:0] hmem [256];
  logic [31:0] lmem [256];
  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dma_chain_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .host_req_valid(host_req_valid), .host_req_ready(host_req_ready),
    .host_req_write(host_req_write), .host_req_addr(host_req_addr),
    .host_req_wdata(host_req_wdata), .host_rsp_valid(host_rsp_valid),
    .host_rsp_data(host_rsp_data),
    .local_req_valid(local_req_valid), .local_req_ready(local_req_ready),
    .local_req_write(local_req_write), .local_req_addr(local_req_addr),
    .local_req_wdata(local_req_wdata), .local_rsp_valid(local_rsp_valid),
    .local_rsp_data(local_rsp_data)
  );

  function automatic logic [31:0] hp(input int i);
    return 32'hA500_0000 | 32'(i & 255);
  endfunction
  function automatic logic [31:0] lp(input int i);
    return 32'h5A00_0000 | 32'(i & 255);
  endfunction

  // memory models: one-cycle read response, ready toggles in a fixed pattern
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      host_rsp_valid  <= 1'b0;
      local_rsp_valid <= 1'b0;
    end else begin
      host_rsp_valid  <= 1'b0;
      local_rsp_valid <= 1'b0;
      if (host_req_valid && host_req_ready) begin
        if (host_req_write) hmem[host_req_addr[9:2]] = host_req_wdata;
        else begin
          host_rsp_valid <= 1'b1;
          host_rsp_data  <= hmem[host_req_addr[9:2]];
        end
      end
      if (local_req_valid && local_req_ready) begin
        if (local_req_write) lmem[local_req_addr[9:2]] = local_req_wdata;
        else begin
          local_rsp_valid <= 1'b1;
          local_rsp_data  <= lmem[local_req_addr[9:2]];
        end
      end
    end
    host_req_ready  <= (cyc % 4) != 3;
    local_req_ready <= (cyc % 3) != 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired actual %0d expected below 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int i = 0; i < 256; i++) begin
      hmem[i] = hp(i);
      lmem[i] = lp(i);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    repeat (2) @(negedge clk);
    for (int n = 0; n < 5000; n++) begin
      rd(3'd5, s);
      if (!s[6]) return;
    end
    chk("busy timeout", s[6], 1'b0);
  endtask

  // mode, host address, local address, count
  localparam logic [31:0] VEC [6][4] = '{
    '{32'h00, 32'h000, 32'h200, 32'd4},
    '{32'h08, 32'h010, 32'h210, 32'd13},
    '{32'h10, 32'h240, 32'h020, 32'd8},
    '{32'h02, 32'h020, 32'h280, 32'd12},
    '{32'h08, 32'h050, 32'h2A0, 32'd0},
    '{32'h00, 32'h030, 32'h2C0, 32'h0080_0008}
  };

  initial begin
    logic [31:0] v, c1, c2;
    init_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int r = 0; r < 6; r++) begin
      rd(3'(r), v);
      chk("R1 register after reset", v, 32'd0);
    end
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 no request after reset", {30'd0, host_req_valid, local_req_valid}, 32'd0);

    // R2 start without enable does nothing
    wr(3'd3, 32'd8);
    wr(3'd5, 32'h02);
    repeat (5) @(negedge clk);
    rd(3'd5, v);
    chk("R2 start ignored without enable", v & 32'h50, 32'h0);
    rd(3'd3, v);
    chk("R2 count untouched", v, 32'd8);

    // direct transfers from the vector table
    for (int k = 0; k < 6; k++) begin
      int hb, lb, beats, cnt;
      logic [31:0] m;
      m = VEC[k][0];
      hb = int'(VEC[k][1] >> 2);
      lb = int'(VEC[k][2] >> 2);
      cnt = int'(VEC[k][3] & 32'h007F_FFFF);
      beats = (cnt + 3) / 4;
      init_mem();
      wr(3'd5, 32'h08);
      wr(3'd0, m);
      wr(3'd1, VEC[k][1]);
      wr(3'd2, VEC[k][2]);
      wr(3'd3, VEC[k][3]);
      rd(3'd3, v);
      chk("R14 count keeps low 23 bits", v, 32'(cnt));
      wr(3'd5, 32'h03);
      wait_idle();
      if (m[4]) begin
        for (int i = 0; i < beats; i++)
          chk("R3 local-to-host data", hmem[(hb + i) & 255], lp(lb + i));
        chk("R3 host word past end untouched", hmem[(hb + beats) & 255], hp(hb + beats));
      end else if (m[1]) begin
        chk("R5 held local gets last word", lmem[lb], hp(hb + beats - 1));
        chk("R5 next local word untouched", lmem[(lb + 1) & 255], lp(lb + 1));
      end else begin
        for (int i = 0; i < beats; i++)
          chk("R3 host-to-local data", lmem[(lb + i) & 255], hp(hb + i));
        chk("R10 local word past end untouched", lmem[(lb + beats) & 255], lp(lb + beats));
      end
      rd(3'd3, v);
      chk("R4 final count", v, 32'd0);
      rd(3'd1, v);
      chk("R4 final host address", v, VEC[k][1] + 32'(4 * beats));
      rd(3'd2, v);
      chk("R4 R5 final local address", v, m[1] ? VEC[k][2] : VEC[k][2] + 32'(4 * beats));
      rd(3'd5, v);
      chk("R2 done status", v & 32'h50, 32'h10);
      chk("R9 irq follows done enable", {31'd0, irq}, {31'd0, m[3]});
    end

    // R9 clear interrupt
    wr(3'd5, 32'h08);
    @(negedge clk);
    chk("R9 clear interrupt", {31'd0, irq}, 32'd0);

    // chain in mixed memories with clear-count and done interrupt
    init_mem();
    hmem[64] = 32'h000; hmem[65] = 32'h040; hmem[66] = 32'd10;  hmem[67] = 32'h304;
    lmem[192] = 32'h080; lmem[193] = 32'h010; lmem[194] = 32'd0; lmem[195] = 32'h141;
    hmem[80] = 32'h0C0; hmem[81] = 32'h080; hmem[82] = 32'd8;   hmem[83] = 32'h00A;
    wr(3'd0, 32'h0D);
    wr(3'd4, 32'h101);
    wr(3'd5, 32'h03);
    wait_idle();
    for (int i = 0; i < 3; i++)
      chk("R6 first element data", lmem[16 + i], hp(i));
    chk("R6 first element length", lmem[19], lp(19));
    chk("R10 zero element moved nothing", lmem[4], lp(4));
    for (int i = 0; i < 2; i++)
      chk("R7 direction bit local-to-host", hmem[48 + i], lp(32 + i));
    chk("R7 last element length", hmem[50], hp(50));
    chk("R8 count cleared element 1", hmem[66], 32'd0);
    chk("R8 count cleared element 3", hmem[82], 32'd0);
    rd(3'd4, v);
    chk("R7 pointer follows next word", v, 32'h141);
    rd(3'd1, v);
    chk("R6 final host address", v, 32'h0C8);
    chk("R7 R9 irq set", {31'd0, irq}, 32'd1);

    // single local-memory element, no clear-count, no interrupts
    wr(3'd5, 32'h08);
    init_mem();
    lmem[240] = 32'h200; lmem[241] = 32'h100; lmem[242] = 32'd4; lmem[243] = 32'h002;
    wr(3'd0, 32'h01);
    wr(3'd4, 32'h3C0);
    wr(3'd5, 32'h03);
    wait_idle();
    chk("R6 local list data", lmem[64], hp(128));
    chk("R6 local list length", lmem[65], lp(65));
    chk("R8 count kept when mode off", lmem[242], 32'd4);
    chk("R9 no irq when disabled", {31'd0, irq}, 32'd0);
    rd(3'd5, v);
    chk("R7 end bit stops chain", v & 32'h50, 32'h10);

    // R11 abort
    init_mem();
    wr(3'd0, 32'h00);
    wr(3'd1, 32'h000);
    wr(3'd2, 32'h000);
    wr(3'd3, 32'd400);
    wr(3'd5, 32'h03);
    repeat (40) @(negedge clk);
    wr(3'd5, 32'h05);
    wait_idle();
    rd(3'd3, c1);
    chk("R11 abort stopped early", {31'd0, (c1 != 0) && (c1 < 400)}, 32'd1);
    begin
      int done_beats;
      done_beats = (400 - int'(c1)) / 4;
      rd(3'd1, v);
      chk("R11 host address matches words moved", v, 32'(4 * done_beats));
      chk("R11 last word completed", lmem[done_beats - 1], hp(done_beats - 1));
      chk("R11 next word untouched", lmem[done_beats], lp(done_beats));
    end
    rd(3'd5, v);
    chk("R11 done after abort", v & 32'h54, 32'h10);
    chk("R11 irq clear after abort", {31'd0, irq}, 32'd0);
    repeat (20) @(negedge clk);
    rd(3'd3, c2);
    chk("R11 no progress after abort", c2, c1);

    // R12 pause and resume, R13 busy writes ignored
    init_mem();
    wr(3'd1, 32'h000);
    wr(3'd2, 32'h100);
    wr(3'd3, 32'd64);
    wr(3'd5, 32'h03);
    repeat (6) @(negedge clk);
    wr(3'd5, 32'h00);
    repeat (10) @(negedge clk);
    rd(3'd3, c1);
    repeat (30) @(negedge clk);
    rd(3'd3, c2);
    chk("R12 paused count stable", c2, c1);
    chk("R12 paused before end", {31'd0, c1 != 0}, 32'd1);
    rd(3'd5, v);
    chk("R12 still busy while paused", v & 32'h40, 32'h40);
    wr(3'd1, 32'hFFF0);
    wr(3'd5, 32'h01);
    wait_idle();
    rd(3'd1, v);
    chk("R13 busy write ignored", v, 32'h040);
    for (int i = 0; i < 16; i++)
      chk("R12 resumed data", lmem[64 + i], hp(i));
    rd(3'd3, v);
    chk("R12 resumed to zero count", v, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule